// File: doc/BRIEF.md
# Packet Network Controller

A memory-mapped network interface built around one shared packet buffer. Software fills the buffer, programs a transmit length and issues a send command; the block then streams those bytes out on an outbound valid/ready byte interface and marks the final byte. To take in a packet, software issues a receive command. The block then accepts the next waiting packet from an inbound valid/ready byte stream into the buffer, starting at offset 0, and records its length.

The inbound producer announces each complete packet it holds with a one-cycle push pulse. The block keeps a small count of announced packets, and that count decides whether a receive command finds a packet and whether more remain afterwards. A level interrupt is high while either of the two event bits of the status register is set. Reading the status register returns its value and clears those bits. The buffer window spans offsets 0x0000 to 0x3fff. The implemented buffer depth is a parameter of at most 16384 bytes, and window offsets beyond it read as zero.

Top module: `pktnic`

## Requirements
- R1: A bus write to a buffer offset below BUF_BYTES stores the low data byte. A bus read returns that byte in bits 7:0 of `busRdata` on the cycle after the request. Offsets in 0x0000..0x3fff at or above BUF_BYTES read 0 and ignore writes.
- R2: Writing 0x01 to the command register (offset 0x4020) sends buffer bytes 0..L-1 in order on `txData`, with `txLast` high only on byte L-1. While `txReady` is low, `txData` and `txLast` stay unchanged.
- R3: A transmit length written to offset 0x4010 above BUF_BYTES is clamped to BUF_BYTES. A send with length 0 emits no bytes.
- R4: Writing 0x00 to the command register with at least one announced packet accepts that packet into the buffer from offset 0. Afterwards a read of 0x4010 returns its byte count, and status bit 0 (value 0x01) is set.
- R5: An inbound packet longer than BUF_BYTES stores only its first BUF_BYTES bytes and reports a length of BUF_BYTES. Its remaining bytes are still consumed up to and including the end marker.
- R6: A receive command with no announced packet never raises `rxReady`. It leaves status bit 0 clear and sets the received length to 0.
- R7: When a receive completes, status bit 1 (value 0x02) is set if further announced packets are still waiting, and cleared otherwise.
- R8: `irq` is high exactly while status bit 0 or bit 1 is set. A read of the status register (offset 0x4000) returns the bits and clears both, so `irq` is low in the following cycle.
- R9: Status bit 2 (value 0x04) reads 1 while a transfer is in progress and never drives `irq`. During a transfer, commands are ignored, buffer writes from the bus are ignored and buffer reads return 0.
- R10: Command values other than 0x00 and 0x01 have no effect.
- R11: After reset, `irq`, `txValid` and `rxReady` are low, and the status and received-length registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busEn | input | 1 | Bus request this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 15 | Byte offset within the block |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read request |
| rxData | input | 8 | Inbound byte |
| rxValid | input | 1 | Inbound byte present |
| rxLast | input | 1 | Inbound byte ends its packet |
| rxReady | output | 1 | Block accepts inbound bytes |
| rxPktPush | input | 1 | Producer announces one more complete packet |
| txData | output | 8 | Outbound byte |
| txValid | output | 1 | Outbound byte present |
| txLast | output | 1 | Outbound byte ends the packet |
| txReady | input | 1 | Consumer takes the outbound byte |
| irq | output | 1 | Level interrupt from status bits 0 and 1 |

## Verification
If the byte index drifts, the mistake shows on the outbound port within one accepted byte, either as a wrong byte or as a misplaced end marker. It also shows in the next buffer read-back after a receive. If the packet count is off, the mistake first appears at the next receive command: bit 1 is wrong, or `rxReady` rises with nothing queued or stays low with a packet waiting. If the status or clamp logic is wrong, the mistake shows on `irq` one cycle after the completing byte or the status read, or as a byte count that differs from the clamped length.

// File: rtl/pktnic_pkg.sv
package pktnic_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RX,
    ST_TX
  } engState_t;

  // Strobes from the control engine to the datapath
  typedef struct packed {
    logic busy;      // a transfer owns the buffer
    logic memWrite;  // store the inbound byte at the engine index
    logic rxDone;    // a receive command finishes this cycle
    logic rxGot;     // it carried a packet
    logic rxMore;    // packets remain waiting afterwards
  } engStrobe_t;

  localparam logic [14:0] OFS_STATUS  = 15'h4000;
  localparam logic [14:0] OFS_LENGTH  = 15'h4010;
  localparam logic [14:0] OFS_COMMAND = 15'h4020;

  localparam logic [31:0] CMD_RECV = 32'h0;
  localparam logic [31:0] CMD_SEND = 32'h1;

endpackage

// File: rtl/pktnic_ctrl.sv
module pktnic_ctrl
  import pktnic_pkg::*;
#(
  parameter int BUF_BYTES = 1024,
  parameter int RXQ_DEPTH = 4,
  parameter int AW = $clog2(BUF_BYTES),
  parameter int LW = $clog2(BUF_BYTES + 1),
  parameter int QW = $clog2(RXQ_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdRecv,
  input  logic          cmdSend,
  input  logic [LW-1:0] txLen,
  input  logic          rxValid,
  input  logic          rxLast,
  input  logic          rxPktPush,
  input  logic          txReady,
  output logic          rxReady,
  output logic          txValid,
  output logic          txLast,
  output logic [AW-1:0] bufIdx,
  output logic [LW-1:0] doneLen,
  output engStrobe_t    strobes
);

  localparam logic [LW-1:0] BUF_LIMIT = LW'(BUF_BYTES);
  localparam logic [QW-1:0] Q_FULL    = QW'(RXQ_DEPTH);

  engState_t     state;
  logic [LW-1:0] idx;
  logic [QW-1:0] pktCount;
  logic [QW-1:0] pktNext;

  logic rxAccept, endPkt, room, noPkt, qInc, qDec, txFire, txEnd;
  logic [LW-1:0] storedLen;

  always_comb begin
    rxAccept  = (state == ST_RX) && rxValid;
    endPkt    = rxAccept && rxLast;
    room      = idx < BUF_LIMIT;
    storedLen = room ? idx + LW'(1) : idx;
    noPkt     = (state == ST_IDLE) && cmdRecv && (pktCount == '0);
    qInc      = rxPktPush && (pktCount != Q_FULL);
    qDec      = endPkt && (pktCount != '0);
    pktNext   = pktCount + QW'(qInc) - QW'(qDec);
    txFire    = (state == ST_TX) && txReady;
    txEnd     = idx == (txLen - LW'(1));

    strobes.busy     = state != ST_IDLE;
    strobes.memWrite = rxAccept && room;
    strobes.rxDone   = endPkt || noPkt;
    strobes.rxGot    = endPkt;
    strobes.rxMore   = endPkt && (pktNext != '0);

    doneLen = endPkt ? storedLen : '0;
    rxReady = state == ST_RX;
    txValid = state == ST_TX;
    txLast  = (state == ST_TX) && txEnd;
    bufIdx  = idx[AW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idx      <= '0;
      pktCount <= '0;
    end else begin
      pktCount <= pktNext;
      unique case (state)
        ST_IDLE: begin
          if (cmdSend && txLen != '0) begin
            state <= ST_TX;
            idx   <= '0;
          end else if (cmdRecv && pktCount != '0) begin
            state <= ST_RX;
            idx   <= '0;
          end
        end
        ST_RX: begin
          if (rxAccept) begin
            if (rxLast)    state <= ST_IDLE;
            else if (room) idx   <= idx + LW'(1);
          end
        end
        ST_TX: begin
          if (txFire) begin
            if (txEnd) state <= ST_IDLE;
            else       idx   <= idx + LW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pktnic_datapath.sv
module pktnic_datapath
  import pktnic_pkg::*;
#(
  parameter int BUF_BYTES = 1024,
  parameter int AW = $clog2(BUF_BYTES),
  parameter int LW = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busEn,
  input  logic          busWe,
  input  logic [14:0]   busAddr,
  input  logic [31:0]   busWdata,
  output logic [31:0]   busRdata,
  input  engStrobe_t    strobes,
  input  logic [AW-1:0] bufIdx,
  input  logic [LW-1:0] rxLenIn,
  input  logic [7:0]    rxByte,
  output logic [7:0]    txByte,
  output logic [LW-1:0] txLen,
  output logic          cmdRecv,
  output logic          cmdSend,
  output logic          irq
);

  localparam logic [14:0] BUF_LIMIT = 15'(BUF_BYTES);

  logic [7:0]    mem [BUF_BYTES];
  logic          statGot, statMore;
  logic [LW-1:0] rxLenQ;
  logic          bufHit, statusRd, lenWr, cmdWr;
  logic [31:0]   rdNext;

  always_comb begin
    bufHit   = busEn && !busAddr[14] && ({1'b0, busAddr[13:0]} < BUF_LIMIT);
    statusRd = busEn && !busWe && (busAddr == OFS_STATUS);
    lenWr    = busEn && busWe && (busAddr == OFS_LENGTH);
    cmdWr    = busEn && busWe && (busAddr == OFS_COMMAND);
    cmdRecv  = cmdWr && (busWdata == CMD_RECV);
    cmdSend  = cmdWr && (busWdata == CMD_SEND);
    irq      = statGot || statMore;
    txByte   = mem[bufIdx];

    if (bufHit)
      rdNext = strobes.busy ? 32'h0 : {24'h0, mem[busAddr[AW-1:0]]};
    else if (busAddr == OFS_STATUS)
      rdNext = {29'h0, strobes.busy, statMore, statGot};
    else if (busAddr == OFS_LENGTH)
      rdNext = 32'(rxLenQ);
    else
      rdNext = 32'h0;
  end

  // Buffer: the engine has the write port while it receives
  always_ff @(posedge clk) begin
    if (strobes.memWrite)
      mem[bufIdx] <= rxByte;
    else if (bufHit && busWe && !strobes.busy)
      mem[busAddr[AW-1:0]] <= busWdata[7:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statGot  <= 1'b0;
      statMore <= 1'b0;
      rxLenQ   <= '0;
      txLen    <= '0;
      busRdata <= '0;
    end else begin
      if (strobes.rxDone) begin
        statGot  <= strobes.rxGot;
        statMore <= strobes.rxMore;
        rxLenQ   <= rxLenIn;
      end else if (statusRd) begin
        statGot  <= 1'b0;
        statMore <= 1'b0;
      end
      if (lenWr)
        txLen <= (busWdata > 32'(BUF_BYTES)) ? LW'(BUF_BYTES) : busWdata[LW-1:0];
      if (busEn && !busWe)
        busRdata <= rdNext;
    end
  end

endmodule

// File: rtl/pktnic.sv
module pktnic
  import pktnic_pkg::*;
#(
  parameter int BUF_BYTES = 1024,
  parameter int RXQ_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busEn,
  input  logic        busWe,
  input  logic [14:0] busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic [7:0]  rxData,
  input  logic        rxValid,
  input  logic        rxLast,
  output logic        rxReady,
  input  logic        rxPktPush,
  output logic [7:0]  txData,
  output logic        txValid,
  output logic        txLast,
  input  logic        txReady,
  output logic        irq
);

  localparam int AW = $clog2(BUF_BYTES);
  localparam int LW = $clog2(BUF_BYTES + 1);
  localparam int QW = $clog2(RXQ_DEPTH + 1);

  engStrobe_t    engStrobes;
  logic [AW-1:0] bufIdx;
  logic [LW-1:0] doneLen, txLen;
  logic [7:0]    txByte;
  logic          cmdRecv, cmdSend;

  pktnic_ctrl #(
    .BUF_BYTES(BUF_BYTES), .RXQ_DEPTH(RXQ_DEPTH), .AW(AW), .LW(LW), .QW(QW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdRecv(cmdRecv), .cmdSend(cmdSend), .txLen(txLen),
    .rxValid(rxValid), .rxLast(rxLast), .rxPktPush(rxPktPush), .txReady(txReady),
    .rxReady(rxReady), .txValid(txValid), .txLast(txLast), .bufIdx(bufIdx),
    .doneLen(doneLen), .strobes(engStrobes)
  );

  pktnic_datapath #(
    .BUF_BYTES(BUF_BYTES), .AW(AW), .LW(LW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .strobes(engStrobes), .bufIdx(bufIdx),
    .rxLenIn(doneLen), .rxByte(rxData), .txByte(txByte), .txLen(txLen),
    .cmdRecv(cmdRecv), .cmdSend(cmdSend), .irq(irq)
  );

  assign txData = txValid ? txByte : 8'h00;

endmodule

// File: rtl/pktnic_checker.sv
module pktnic_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busEn,
  input logic        busWe,
  input logic [14:0] busAddr,
  input logic        rxReady,
  input logic        txValid,
  input logic        txReady,
  input logic [7:0]  txData,
  input logic        txLast,
  input logic        irq,
  input logic        rxDone
);

  // R9: only one transfer direction owns the buffer at a time
  p_one_transfer_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxReady |-> !txValid);

  // R2: a stalled outbound byte is held unchanged
  p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txLast)));

  // R2: the packet ends after its marked byte is taken
  p_tx_end_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && txLast) |=> !txValid);

  // R8: a status read with no completion in the same cycle drops the interrupt
  p_status_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && !busWe && busAddr == 15'h4000 && !rxDone) |=> !irq);

  // R8: the interrupt rises only from a completed receive
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(rxDone));

endmodule

bind pktnic pktnic_checker u_chk (
  .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
  .rxReady(rxReady), .txValid(txValid), .txReady(txReady), .txData(txData),
  .txLast(txLast), .irq(irq), .rxDone(engStrobes.rxDone)
);

// File: tb/sim_pktnic.sv
module sim_pktnic;

  localparam int BUF = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEn = 1'b0, busWe = 1'b0;
  logic [14:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  rxData = '0;
  logic        rxValid = 1'b0, rxLast = 1'b0, rxPktPush = 1'b0;
  logic        rxReady;
  logic [7:0]  txData;
  logic        txValid, txLast, irq;
  logic        txReady = 1'b0;

  always #4 clk = ~clk;

  pktnic #(.BUF_BYTES(BUF), .RXQ_DEPTH(4)) u0 (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rxData(rxData), .rxValid(rxValid),
    .rxLast(rxLast), .rxReady(rxReady), .rxPktPush(rxPktPush), .txData(txData),
    .txValid(txValid), .txLast(txLast), .txReady(txReady), .irq(irq)
  );

  int nChecks = 0, nFail = 0;

  // inbound source model
  logic [7:0] srcData [256];
  logic       srcLast [256];
  int srcHead = 0, srcTail = 0;
  logic sawRx = 1'b0;

  // outbound sink model
  logic [7:0] snkData [128];
  logic       snkLast [128];
  int snkCnt = 0, stallCnt = 0;
  logic sawTx = 1'b0;

  // {addr, write byte, expected read byte}
  localparam logic [30:0] VECS [8] = '{
    {15'h0000, 8'h11, 8'h11},
    {15'h0001, 8'h22, 8'h22},
    {15'h003f, 8'h5a, 8'h5a},
    {15'h0020, 8'hff, 8'hff},
    {15'h0040, 8'h77, 8'h00},
    {15'h3fff, 8'h99, 8'h00},
    {15'h0010, 8'h00, 8'h00},
    {15'h0002, 8'hc3, 8'hc3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  task automatic busWrite(input logic [14:0] a, input logic [31:0] d);
    @(negedge clk);
    busEn = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busEn = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [14:0] a, output logic [31:0] d);
    @(negedge clk);
    busEn = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk);
    busEn = 1'b0;
    d = busRdata;
  endtask

  task automatic pushPacket(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      srcData[(srcTail + i) % 256] = seed + 8'(i);
      srcLast[(srcTail + i) % 256] = (i == n - 1);
    end
    @(negedge clk);
    srcTail = srcTail + n;
    rxPktPush = 1'b1;
    @(negedge clk);
    rxPktPush = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      rxValid = (srcHead != srcTail);
      rxData  = srcData[srcHead % 256];
      rxLast  = srcLast[srcHead % 256];
      #1;
      if (rxReady) sawRx = 1'b1;
      if (rxValid && rxReady) srcHead++;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      txReady = (stallCnt % 4) != 3;
      stallCnt++;
      #1;
      if (txValid) sawTx = 1'b1;
      if (txValid && txReady && snkCnt < 128) begin
        snkData[snkCnt] = txData;
        snkLast[snkCnt] = txLast;
        snkCnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    srcData[0] = '0; srcLast[0] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 irq", 32'(irq), 32'h0);
    check("R11 txValid", 32'(txValid), 32'h0);
    check("R11 rxReady", 32'(rxReady), 32'h0);
    busRead(15'h4000, rd); check("R11 status", rd, 32'h0);
    busRead(15'h4010, rd); check("R11 length", rd, 32'h0);

    // R1 buffer access table
    for (int v = 0; v < 8; v++) begin
      busWrite(VECS[v][30:16], {24'hABCDEF, VECS[v][15:8]});
      busRead(VECS[v][30:16], rd);
      check("R1 buffer", rd, {24'h0, VECS[v][7:0]});
    end

    // R2 transmit with stalls, R9 busy behaviour
    for (int i = 0; i < 10; i++) busWrite(15'(i), 32'(8'hA0 + 8'(i)));
    busWrite(15'h4010, 32'd10);
    snkCnt = 0;
    busWrite(15'h4020, 32'h1);
    busRead(15'h4000, rd); check("R9 busy bit", rd, 32'h4);
    check("R9 busy no irq", 32'(irq), 32'h0);
    busRead(15'h0001, rd); check("R9 buffer read while busy", rd, 32'h0);
    busWrite(15'h0000, 32'h55);
    busWrite(15'h4020, 32'h1);
    repeat (40) @(negedge clk);
    check("R2 byte count", snkCnt, 32'd10);
    for (int i = 0; i < 10; i++) begin
      check("R2 tx byte", 32'(snkData[i]), 32'(8'hA0 + 8'(i)));
      check("R2 tx last", 32'(snkLast[i]), 32'(i == 9));
    end
    busRead(15'h0000, rd); check("R9 write while busy ignored", rd, 32'hA0);

    // R3 clamp and zero length
    busWrite(15'h4010, 32'd1000);
    snkCnt = 0;
    busWrite(15'h4020, 32'h1);
    repeat (120) @(negedge clk);
    check("R3 clamped count", snkCnt, 32'd64);
    check("R3 clamped last", 32'(snkLast[63]), 32'h1);
    check("R3 clamped byte", 32'(snkData[63]), 32'h5a);
    busWrite(15'h4010, 32'd0);
    snkCnt = 0; sawTx = 1'b0;
    busWrite(15'h4020, 32'h1);
    repeat (10) @(negedge clk);
    check("R3 zero length", 32'(sawTx), 32'h0);

    // R4 R7 R8 two queued packets
    pushPacket(5, 8'h30);
    pushPacket(3, 8'h70);
    busWrite(15'h4020, 32'h0);
    repeat (20) @(negedge clk);
    check("R8 irq set", 32'(irq), 32'h1);
    busRead(15'h4010, rd); check("R4 length", rd, 32'd5);
    busRead(15'h4000, rd); check("R7 status more", rd, 32'h3);
    check("R8 irq cleared", 32'(irq), 32'h0);
    busRead(15'h4000, rd); check("R8 status cleared", rd, 32'h0);
    for (int i = 0; i < 5; i++) begin
      busRead(15'(i), rd); check("R4 rx byte", rd, 32'(8'h30 + 8'(i)));
    end
    busWrite(15'h4020, 32'h0);
    repeat (20) @(negedge clk);
    busRead(15'h4010, rd); check("R4 second length", rd, 32'd3);
    busRead(15'h4000, rd); check("R7 status last", rd, 32'h1);

    // R5 oversized packet
    pushPacket(70, 8'h00);
    busWrite(15'h4020, 32'h0);
    repeat (90) @(negedge clk);
    busRead(15'h4010, rd); check("R5 truncated length", rd, 32'd64);
    busRead(15'h003f, rd); check("R5 last stored byte", rd, 32'h3f);
    check("R5 tail consumed", 32'(srcHead == srcTail), 32'h1);
    check("R5 rxReady low", 32'(rxReady), 32'h0);
    busRead(15'h4000, rd); check("R5 status", rd, 32'h1);

    // R6 receive with nothing queued
    sawRx = 1'b0;
    busWrite(15'h4020, 32'h0);
    repeat (10) @(negedge clk);
    check("R6 no rxReady", 32'(sawRx), 32'h0);
    check("R6 irq", 32'(irq), 32'h0);
    busRead(15'h4010, rd); check("R6 length zero", rd, 32'h0);
    busRead(15'h4000, rd); check("R6 status", rd, 32'h0);

    // R10 unknown command
    busWrite(15'h4010, 32'd4);
    pushPacket(2, 8'hE0);
    sawTx = 1'b0; sawRx = 1'b0;
    busWrite(15'h4020, 32'h5);
    repeat (10) @(negedge clk);
    check("R10 no transmit", 32'(sawTx), 32'h0);
    check("R10 no receive", 32'(sawRx), 32'h0);
    busRead(15'h4000, rd); check("R10 status", rd, 32'h0);

    finishRun();
  end

endmodule